// File: doc/BRIEF.md
# Next Line Fetch Predictor

This block sits beside an instruction cache whose lines hold eight 32-bit words. Every line has a lower half (words 0 to 3) and an upper half (words 4 to 7), and each half of each line, in every set and every way, owns one prediction slot. A slot names the cache line (set index plus way) that the fetch unit should read after the current one. On every fetch the block chooses one slot and loads its value into a prediction register, which the fetch unit uses as the address of its next line.

The slot is picked by the half that holds the fetch group's first word. When the group carries the delay slot of a control transfer that is predicted taken, the slot is instead picked by the half that holds that delay slot. In that case the slot stands for the transfer's target line, and the fetch unit always supplies the target of the last taken transfer in the group. A slot that has never been written is invalid. With no taken transfer, an invalid slot falls back to the line holding the next sequential word. With a taken transfer, an invalid slot takes the supplied target, and that target is installed in the slot.

When a later redirect shows that a prediction was wrong, the fetch unit issues a correction. The correction writes the right line into the slot at fault and starts a two-cycle stall.

Top module: `nlp_fetch_predictor`

## Requirements
- R1: After reset, pred_idx and pred_way are 0, stall is 0, and every slot is invalid.
- R2: Without a taken-transfer delay slot, the slot is chosen by bit 2 of fetch_word. Words 0 to 3 select the lower half and words 4 to 7 select the upper half. A group that starts in the lower half and crosses into the upper half still uses the lower half.
- R3: An invalid lower-half slot with no taken transfer predicts the same set and the same way as the fetched line.
- R4: An invalid upper-half slot with no taken transfer predicts set fetch_idx+1 in the same way, wrapping from the last set to set 0.
- R5: When ds_present is 1, the slot is chosen by bit 2 of ds_word, whatever fetch_word holds.
- R6: When ds_present is 1 and the chosen slot is invalid, the prediction is ds_tgt_idx/ds_tgt_way, and that target is written into the slot as valid.
- R7: A correction writes fix_tgt_idx/fix_tgt_way into the slot named by fix_idx, fix_way and fix_half (0 means lower half). Later fetches that select that slot predict the stored line.
- R8: A correction raises stall for exactly the two cycles after it is sampled. A new correction during a stall restarts the two-cycle count.
- R9: When a correction and a fetch address the same slot in the same cycle, the fetch sees the corrected value (write-first). An install from the same fetch does not overwrite the correction.
- R10: In a cycle without fetch_valid, pred_idx and pred_way keep their values.
- R11: Slots are separate for every set, way and half. Writing one slot leaves the predictions of the others unchanged.
- R12: When ds_present is 1 and the chosen slot is already valid, the slot's value is predicted and ds_tgt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | A fetch group is presented this cycle |
| fetch_idx | input | IW | Set index of the line being fetched |
| fetch_way | input | WW | Way of the line being fetched |
| fetch_word | input | 3 | Word position of the group's first instruction |
| ds_present | input | 1 | Group holds the delay slot of a predicted-taken transfer |
| ds_word | input | 3 | Word position of the last such delay slot |
| ds_tgt_idx | input | IW | Set index of the line holding the last transfer's target |
| ds_tgt_way | input | WW | Way of the line holding that target |
| fix_valid | input | 1 | Correction of a wrong prediction |
| fix_idx | input | IW | Set of the slot at fault |
| fix_way | input | WW | Way of the slot at fault |
| fix_half | input | 1 | Half of the slot at fault (0 lower, 1 upper) |
| fix_tgt_idx | input | IW | Correct next-line set index |
| fix_tgt_way | input | WW | Correct next-line way |
| pred_idx | output | IW | Predicted next-line set index |
| pred_way | output | WW | Predicted next-line way |
| stall | output | 1 | High during the two correction stall cycles |

## Verification
Two functions can fall in the same cycle: a correction write, and a fetch lookup (with a possible install) of the same slot. The bench drives a correction and a fetch that select one slot on the same clock edge. In one case the fetch carries no taken transfer. In the other it carries a taken transfer with a different target, so that an install is attempted. The prediction register must show the corrected line in both cases. A fetch made later from that slot must still return the corrected line, which shows that the install lost to the correction.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

  // cycles the fetch unit is held after a correction
  localparam int STALL_CYCLES = 2;

  // set that follows set_i, wrapping at the end of the cache
  function automatic int next_set(input int set_i, input int num_sets);
    return (set_i + 1 >= num_sets) ? 0 : set_i + 1;
  endfunction

  // flat position of one half-line slot
  function automatic int slot_addr(input int set_i, input int way_i,
                                   input int half_i, input int num_ways);
    return ((set_i * num_ways) + way_i) * 2 + half_i;
  endfunction

endpackage

// File: rtl/nlp_slot_table.sv
module nlp_slot_table #(
  parameter int SETS = 64,
  parameter int WAYS = 2,
  parameter int IW   = 6,
  parameter int WW   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_set,
  input  logic [WW-1:0] rd_way,
  input  logic          rd_half,
  output logic          rd_valid,
  output logic [IW-1:0] rd_idx,
  output logic [WW-1:0] rd_tway,
  input  logic          ins_we,
  input  logic [IW-1:0] ins_idx,
  input  logic [WW-1:0] ins_tway,
  input  logic          fix_we,
  input  logic [IW-1:0] fix_set,
  input  logic [WW-1:0] fix_way,
  input  logic          fix_half,
  input  logic [IW-1:0] fix_idx,
  input  logic [WW-1:0] fix_tway
);
  import nlp_pkg::*;

  localparam int DEPTH = SETS * WAYS * 2;
  localparam int AW    = $clog2(DEPTH);

  logic          vld_q [DEPTH];
  logic [IW-1:0] idx_q [DEPTH];
  logic [WW-1:0] way_q [DEPTH];

  logic [AW-1:0] rd_addr;
  logic [AW-1:0] fix_addr;
  logic          bypass;
  logic          ins_blocked;

  assign rd_addr  = AW'(slot_addr(int'(rd_set), int'(rd_way), int'(rd_half), WAYS));
  assign fix_addr = AW'(slot_addr(int'(fix_set), int'(fix_way), int'(fix_half), WAYS));
  assign bypass   = fix_we && (fix_addr == rd_addr);
  assign ins_blocked = bypass;

  // write-first read port
  always_comb begin
    if (bypass) begin
      rd_valid = 1'b1;
      rd_idx   = fix_idx;
      rd_tway  = fix_tway;
    end else begin
      rd_valid = vld_q[rd_addr];
      rd_idx   = idx_q[rd_addr];
      rd_tway  = way_q[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
    end else begin
      if (ins_we) vld_q[rd_addr] <= 1'b1;
      if (fix_we) vld_q[fix_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_we && !ins_blocked) begin
      idx_q[rd_addr] <= ins_idx;
      way_q[rd_addr] <= ins_tway;
    end
    if (fix_we) begin
      idx_q[fix_addr] <= fix_idx;
      way_q[fix_addr] <= fix_tway;
    end
  end

  AST_INSTALL_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ins_we |-> !rd_valid); // R6
  AST_FIX_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |=> (vld_q[$past(fix_addr)] && idx_q[$past(fix_addr)] == $past(fix_idx)
                && way_q[$past(fix_addr)] == $past(fix_tway))); // R7
  AST_FIX_BEATS_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_we && ins_we && fix_addr == rd_addr) |=> idx_q[$past(fix_addr)] == $past(fix_idx)); // R9

endmodule

// File: rtl/nlp_select.sv
module nlp_select #(
  parameter int SETS  = 64,
  parameter int IW    = 6,
  parameter int WW    = 1,
  parameter int POS_W = 3
) (
  input  logic             fetch_valid,
  input  logic [IW-1:0]    fetch_idx,
  input  logic [WW-1:0]    fetch_way,
  input  logic [POS_W-1:0] fetch_word,
  input  logic             ds_present,
  input  logic [POS_W-1:0] ds_word,
  input  logic [IW-1:0]    ds_tgt_idx,
  input  logic [WW-1:0]    ds_tgt_way,
  input  logic             slot_valid,
  input  logic [IW-1:0]    slot_idx,
  input  logic [WW-1:0]    slot_way,
  output logic             lk_half,
  output logic [IW-1:0]    nxt_idx,
  output logic [WW-1:0]    nxt_way,
  output logic             ins_we
);
  import nlp_pkg::*;

  logic [IW-1:0] seq_idx;

  assign lk_half = ds_present ? ds_word[POS_W-1] : fetch_word[POS_W-1];
  assign seq_idx = lk_half ? IW'(next_set(int'(fetch_idx), SETS)) : fetch_idx;
  assign ins_we  = fetch_valid && ds_present && !slot_valid;

  always_comb begin
    if (slot_valid) begin
      nxt_idx = slot_idx;
      nxt_way = slot_way;
    end else if (ds_present) begin
      nxt_idx = ds_tgt_idx;
      nxt_way = ds_tgt_way;
    end else begin
      nxt_idx = seq_idx;
      nxt_way = fetch_way;
    end
  end

endmodule

// File: rtl/nlp_stall_timer.sv
module nlp_stall_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic fix_valid,
  output logic stall
);
  import nlp_pkg::*;

  localparam int CW = $clog2(STALL_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (fix_valid)      cnt_q <= CW'(STALL_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign stall = (cnt_q != '0);

  AST_STALL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid |=> stall); // R8
  AST_STALL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid ##1 1'b1 |=> stall); // R8
  AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid ##1 !fix_valid ##1 !fix_valid |=> !stall); // R8

endmodule

// File: rtl/nlp_fetch_predictor.sv
module nlp_fetch_predictor #(
  parameter int SETS       = 64,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 8,
  localparam int IW    = $clog2(SETS),
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int POS_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [IW-1:0]    fetch_idx,
  input  logic [WW-1:0]    fetch_way,
  input  logic [POS_W-1:0] fetch_word,
  input  logic             ds_present,
  input  logic [POS_W-1:0] ds_word,
  input  logic [IW-1:0]    ds_tgt_idx,
  input  logic [WW-1:0]    ds_tgt_way,
  input  logic             fix_valid,
  input  logic [IW-1:0]    fix_idx,
  input  logic [WW-1:0]    fix_way,
  input  logic             fix_half,
  input  logic [IW-1:0]    fix_tgt_idx,
  input  logic [WW-1:0]    fix_tgt_way,
  output logic [IW-1:0]    pred_idx,
  output logic [WW-1:0]    pred_way,
  output logic             stall
);

  // named internal events for the checks
  logic          lk_half;
  logic          slot_valid;
  logic [IW-1:0] slot_idx;
  logic [WW-1:0] slot_way;
  logic [IW-1:0] nxt_idx;
  logic [WW-1:0] nxt_way;
  logic          ins_we;

  nlp_slot_table #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .WW(WW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (fetch_idx),
    .rd_way   (fetch_way),
    .rd_half  (lk_half),
    .rd_valid (slot_valid),
    .rd_idx   (slot_idx),
    .rd_tway  (slot_way),
    .ins_we   (ins_we),
    .ins_idx  (ds_tgt_idx),
    .ins_tway (ds_tgt_way),
    .fix_we   (fix_valid),
    .fix_set  (fix_idx),
    .fix_way  (fix_way),
    .fix_half (fix_half),
    .fix_idx  (fix_tgt_idx),
    .fix_tway (fix_tgt_way)
  );

  nlp_select #(.SETS(SETS), .IW(IW), .WW(WW), .POS_W(POS_W)) u_select (
    .fetch_valid (fetch_valid),
    .fetch_idx   (fetch_idx),
    .fetch_way   (fetch_way),
    .fetch_word  (fetch_word),
    .ds_present  (ds_present),
    .ds_word     (ds_word),
    .ds_tgt_idx  (ds_tgt_idx),
    .ds_tgt_way  (ds_tgt_way),
    .slot_valid  (slot_valid),
    .slot_idx    (slot_idx),
    .slot_way    (slot_way),
    .lk_half     (lk_half),
    .nxt_idx     (nxt_idx),
    .nxt_way     (nxt_way),
    .ins_we      (ins_we)
  );

  nlp_stall_timer u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .fix_valid (fix_valid),
    .stall     (stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_idx <= '0;
      pred_way <= '0;
    end else if (fetch_valid) begin
      pred_idx <= nxt_idx;
      pred_way <= nxt_way;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> ($stable(pred_idx) && $stable(pred_way))); // R10
  AST_SLOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && slot_valid) |=> (pred_idx == $past(slot_idx) && pred_way == $past(slot_way))); // R12
  AST_DS_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && ds_present && !slot_valid) |=> (pred_idx == $past(ds_tgt_idx))); // R6

endmodule

// File: tb/nlp_fetch_predictor_tb.sv
module nlp_fetch_predictor_tb_top;
  localparam int IW = 6;
  localparam int WW = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid;
  logic [IW-1:0] fetch_idx;
  logic [WW-1:0] fetch_way;
  logic [2:0]    fetch_word;
  logic          ds_present;
  logic [2:0]    ds_word;
  logic [IW-1:0] ds_tgt_idx;
  logic [WW-1:0] ds_tgt_way;
  logic          fix_valid;
  logic [IW-1:0] fix_idx;
  logic [WW-1:0] fix_way;
  logic          fix_half;
  logic [IW-1:0] fix_tgt_idx;
  logic [WW-1:0] fix_tgt_way;
  logic [IW-1:0] pred_idx;
  logic [WW-1:0] pred_way;
  logic          stall;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nlp_fetch_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
    .fetch_way(fetch_way), .fetch_word(fetch_word), .ds_present(ds_present),
    .ds_word(ds_word), .ds_tgt_idx(ds_tgt_idx), .ds_tgt_way(ds_tgt_way),
    .fix_valid(fix_valid), .fix_idx(fix_idx), .fix_way(fix_way), .fix_half(fix_half),
    .fix_tgt_idx(fix_tgt_idx), .fix_tgt_way(fix_tgt_way),
    .pred_idx(pred_idx), .pred_way(pred_way), .stall(stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pred(input string req, input int e_idx, input int e_way);
    chk(req, int'(pred_idx), e_idx);
    chk(req, int'(pred_way), e_way);
  endtask

  task automatic clear_inputs();
    fetch_valid = 0; fetch_idx = '0; fetch_way = '0; fetch_word = '0;
    ds_present = 0; ds_word = '0; ds_tgt_idx = '0; ds_tgt_way = '0;
    fix_valid = 0; fix_idx = '0; fix_way = '0; fix_half = 0;
    fix_tgt_idx = '0; fix_tgt_way = '0;
  endtask

  task automatic set_fetch(input int s, input int w, input int word,
                           input bit ds, input int dsw, input int ti, input int tw);
    fetch_valid = 1; fetch_idx = IW'(s); fetch_way = WW'(w); fetch_word = 3'(word);
    ds_present = ds; ds_word = 3'(dsw); ds_tgt_idx = IW'(ti); ds_tgt_way = WW'(tw);
  endtask

  task automatic set_fix(input int s, input int w, input int h, input int ti, input int tw);
    fix_valid = 1; fix_idx = IW'(s); fix_way = WW'(w); fix_half = h[0];
    fix_tgt_idx = IW'(ti); fix_tgt_way = WW'(tw);
  endtask

  // one fetch; returns at the falling edge after the capturing edge
  task automatic do_fetch(input int s, input int w, input int word,
                          input bit ds, input int dsw, input int ti, input int tw);
    @(negedge clk); set_fetch(s, w, word, ds, dsw, ti, tw);
    @(negedge clk); clear_inputs();
  endtask

  task automatic do_fix(input int s, input int w, input int h, input int ti, input int tw);
    @(negedge clk); set_fix(s, w, h, ti, tw);
    @(negedge clk); clear_inputs();
  endtask

  task automatic wait_quiet();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_pred("R1 reset pred", 0, 0);
    chk("R1 reset stall", int'(stall), 0);
  endtask

  task automatic t_sequential();
    do_fetch(5, 1, 0, 0, 0, 0, 0);  chk_pred("R3 lower half same line", 5, 1);
    do_fetch(5, 1, 6, 0, 0, 0, 0);  chk_pred("R4 upper half next set", 6, 1);
    do_fetch(5, 1, 2, 0, 0, 0, 0);  chk_pred("R2 spanning group uses lower half", 5, 1);
    do_fetch(63, 0, 4, 0, 0, 0, 0); chk_pred("R4 wrap to set 0", 0, 0);
    do_fetch(12, 0, 7, 0, 0, 0, 0); chk_pred("R1 untouched slot invalid", 13, 0);
  endtask

  task automatic t_idle();
    do_fetch(40, 1, 5, 0, 0, 0, 0); chk_pred("R10 setup", 41, 1);
    @(negedge clk); fix_valid = 0;
    repeat (3) @(negedge clk);
    chk_pred("R10 hold without fetch", 41, 1);
  endtask

  task automatic t_delay_slot();
    do_fetch(10, 0, 1, 1, 5, 33, 1); chk_pred("R5 R6 ds upper half target", 33, 1);
    do_fetch(10, 0, 4, 0, 0, 0, 0);  chk_pred("R6 target installed", 33, 1);
    do_fetch(10, 0, 0, 0, 0, 0, 0);  chk_pred("R11 other half untouched", 10, 0);
    do_fetch(10, 0, 6, 1, 7, 40, 0); chk_pred("R12 valid slot beats ds target", 33, 1);
    do_fetch(10, 1, 4, 0, 0, 0, 0);  chk_pred("R11 other way untouched", 11, 1);
  endtask

  task automatic t_fix();
    do_fix(20, 1, 0, 7, 0);
    chk("R8 stall cycle 1", int'(stall), 1);
    @(negedge clk); chk("R8 stall cycle 2", int'(stall), 1);
    @(negedge clk); chk("R8 stall cleared", int'(stall), 0);
    do_fetch(20, 1, 3, 0, 0, 0, 0); chk_pred("R7 corrected slot", 7, 0);
    do_fetch(20, 0, 0, 0, 0, 0, 0); chk_pred("R11 neighbour way", 20, 0);
    do_fetch(20, 1, 5, 0, 0, 0, 0); chk_pred("R11 neighbour half", 21, 1);
    do_fix(10, 0, 1, 44, 0);
    wait_quiet();
    do_fetch(10, 0, 4, 0, 0, 0, 0); chk_pred("R7 correction replaces installed", 44, 0);
  endtask

  task automatic t_retrigger();
    do_fix(2, 0, 0, 3, 0);
    set_fix(2, 0, 0, 3, 0);
    @(negedge clk); clear_inputs();
    chk("R8 retrigger cycle 1", int'(stall), 1);
    @(negedge clk); chk("R8 retrigger cycle 2", int'(stall), 1);
    @(negedge clk); chk("R8 retrigger ends", int'(stall), 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    set_fix(30, 0, 1, 50, 1);
    set_fetch(30, 0, 7, 0, 0, 0, 0);
    @(negedge clk); clear_inputs();
    chk_pred("R9 write-first lookup", 50, 1);
    @(negedge clk);
    set_fix(31, 1, 1, 2, 0);
    set_fetch(31, 1, 1, 1, 6, 9, 1);
    @(negedge clk); clear_inputs();
    chk_pred("R9 write-first with ds", 2, 0);
    wait_quiet();
    do_fetch(31, 1, 4, 0, 0, 0, 0); chk_pred("R9 install lost to correction", 2, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_idle();
    t_delay_slot();
    t_fix();
    wait_quiet();
    t_retrigger();
    wait_quiet();
    t_same_cycle();
    summary();
    $finish;
  end

endmodule